// File: doc/BRIEF.md
# Polarity-Selectable Edge Interrupt Collector

This block watches a group of asynchronous interrupt input pins (eight by default). Each pin passes through a chain of synchronizing flops. The synchronized level is compared with its value one cycle earlier to find transitions. A per-channel polarity bit picks which transition counts: rising or falling. A matching transition sets that channel's pending flag, and the flag stays set until software clears it.

A per-channel mask register gates the pending flags. The OR of all unmasked pending flags drives a single request line towards the processor. The line stays high for as long as any unmasked flag remains set. The interrupt handler is therefore expected to clear the flag it serviced. Software reaches the three registers through a simple single-cycle write strobe with a register selector. Reads use a combinational selector and return data with no wait states. Writing a 1 into a pending bit raises that flag directly, which lets software trigger an interrupt.

Top module: `edge_irq_ctrl`

## Requirements
- R1: With polarity bit n at 0, a low-to-high transition on pin n sets pending bit n, and a high-to-low transition on that pin leaves the bit at 0.
- R2: With polarity bit n at 1, a high-to-low transition on pin n sets pending bit n, and a low-to-high transition on that pin leaves the bit at 0.
- R3: A pending bit that is 1 stays 1 until a write of 0 to that bit or a reset, whatever the pin does afterwards.
- R4: `irq_req` is 1 exactly when some channel has both its pending bit and its mask bit at 1. Pending bits whose mask bit is 0 do not raise it.
- R5: `irq_req` stays at 1 on every cycle while an unmasked pending bit remains set, and falls in the cycle after software clears the last such bit.
- R6: Reset clears the pending, mask and polarity registers to 0x00 and holds `irq_req` at 0.
- R7: `wr_sel` and `rd_sel` use the code 0 for pending, 1 for mask and 2 for polarity. Code 3 reads as 0 and writes to it change nothing. A write takes effect at the next clock edge, and a read returns the stored value in the same cycle.
- R8: Writing 1 to a pending bit sets it (software trigger).
- R9: If a qualifying transition is detected in the same cycle that software writes 0 to that pending bit, the bit ends up 1.
- R10: A pin change driven between clock edges is first reflected in the pending bit after the third rising clock edge that follows, and not earlier (two synchronizer flops plus the previous-value compare).
- R11: Changing a polarity bit while the pin is steady does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NCH | Asynchronous interrupt input pins |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | NCH | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | NCH | Read data for `rd_sel`, combinational |
| irq_req | output | 1 | OR of all unmasked pending bits |

## Verification
The assertions assume three things about the inputs. Each write strobe lasts exactly one clock cycle. The pins sit at 0 while reset is applied, so that release from reset does not itself look like a rising transition. Any change of a pending bit with no write in that cycle comes from a detected transition. The stimulus changes every input on the falling clock edge, holds the pins low through reset, and lets each pin level settle for several cycles before clearing flags. As a result, every pending bit observed by a check comes from a single, deliberately placed transition or from a deliberate software write.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // register selector codes shared by write and read paths
   typedef enum logic [1:0] {
      REG_PEND = 2'd0,
      REG_MASK = 2'd1,
      REG_POL  = 2'd2,
      REG_NONE = 2'd3
   } eirq_reg_e;

   localparam int SEL_W = 2;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1)  $error("edge_irq_sync: WIDTH must be at least 1");
   if (STAGES < 2) $error("edge_irq_sync: STAGES must be at least 2");

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] falling_sel,
   output logic [WIDTH-1:0] hit
);

   if (WIDTH < 1) $error("edge_irq_detect: WIDTH must be at least 1");

   logic [WIDTH-1:0] level_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_prev_q <= '0;
      else        level_prev_q <= level;
   end

   // the comparison is between two real samples, so flipping the
   // polarity alone never manufactures a transition
   for (genvar c = 0; c < WIDTH; c++) begin : g_chan
      logic went_up;
      logic went_down;
      assign went_up   =  level[c] & ~level_prev_q[c];
      assign went_down = ~level[c] &  level_prev_q[c];
      assign hit[c]    = falling_sel[c] ? went_down : went_up;
   end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   input  logic [WIDTH-1:0] hit,
   output logic [WIDTH-1:0] pend_q,
   output logic [WIDTH-1:0] mask_q,
   output logic [WIDTH-1:0] pol_q,
   output logic [WIDTH-1:0] rd_data,
   output logic             irq
);

   eirq_reg_e wsel, rsel;
   logic [WIDTH-1:0] pend_d;

   assign wsel = eirq_reg_e'(wr_sel);
   assign rsel = eirq_reg_e'(rd_sel);

   // detected transitions are OR-ed in last so they override a clearing write
   always_comb begin
      if (wr_en && wsel == REG_PEND) pend_d = wr_data | hit;
      else                           pend_d = pend_q  | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         pol_q  <= '0;
      end else begin
         pend_q <= pend_d;
         if (wr_en && wsel == REG_MASK) mask_q <= wr_data;
         if (wr_en && wsel == REG_POL)  pol_q  <= wr_data;
      end
   end

   always_comb begin
      unique case (rsel)
         REG_PEND: rd_data = pend_q;
         REG_MASK: rd_data = mask_q;
         REG_POL:  rd_data = pol_q;
         default:  rd_data = '0;
      endcase
   end

   assign irq = |(pend_q & mask_q);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   irq_pin,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [NCH-1:0]   wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [NCH-1:0]   rd_data,
   output logic             irq_req
);

   if (NCH < 1 || NCH > 64) $error("edge_irq_ctrl: NCH must lie in 1..64");
   if (SYNC_STAGES < 2)     $error("edge_irq_ctrl: SYNC_STAGES must be at least 2");

   logic [NCH-1:0] pin_sync;
   logic [NCH-1:0] edge_hit;
   logic [NCH-1:0] pend_q;
   logic [NCH-1:0] mask_q;
   logic [NCH-1:0] pol_q;

   edge_irq_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pin),
      .q     (pin_sync)
   );

   edge_irq_detect #(.WIDTH(NCH)) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .level       (pin_sync),
      .falling_sel (pol_q),
      .hit         (edge_hit)
   );

   edge_irq_regs #(.WIDTH(NCH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .hit     (edge_hit),
      .pend_q  (pend_q),
      .mask_q  (mask_q),
      .pol_q   (pol_q),
      .rd_data (rd_data),
      .irq     (irq_req)
   );

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk
   import edge_irq_pkg::*;
#(
   parameter int NCH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_sel,
   input logic [NCH-1:0]   wr_data,
   input logic [NCH-1:0]   pend,
   input logic [NCH-1:0]   mask,
   input logic [NCH-1:0]   hit,
   input logic             irq
);

   logic pend_wr, mask_wr;
   assign pend_wr = wr_en && (wr_sel == REG_PEND);
   assign mask_wr = wr_en && (wr_sel == REG_MASK);

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_CLEARS: assert (pend == '0 && mask == '0 && !irq); // R6
   end

   AST_NEW_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_wr |=> (pend & ~$past(pend) & ~$past(hit)) == '0); // R1

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_wr |=> (pend & $past(pend)) == $past(pend)); // R3

   AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pend_wr |=> (pend & $past(wr_data)) == $past(wr_data)); // R8

   AST_CLEAR_LOSES_TO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_wr |=> (($past(hit) & ~pend) == '0) && ((pend & ~$past(wr_data) & ~$past(hit)) == '0)); // R9

   AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend & mask) != '0); // R4

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !pend_wr && !mask_wr) |=> irq); // R5

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .pend    (pend_q),
   .mask    (mask_q),
   .hit     (edge_hit),
   .irq     (irq_req)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;

   localparam int NCH = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_pin = '0;
   logic           wr_en = 1'b0;
   logic [1:0]     wr_sel = '0;
   logic [NCH-1:0] wr_data = '0;
   logic [1:0]     rd_sel = '0;
   logic [NCH-1:0] rd_data;
   logic           irq_req;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   edge_irq_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_pin (irq_pin),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .irq_req (irq_req)
   );

   task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at a negedge; the write lands on the posedge between
   task automatic reg_write(input logic [1:0] sel, input logic [NCH-1:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [NCH-1:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [NCH-1:0] v;

      // R6: reset state
      @(negedge clk); @(negedge clk);
      reg_read(2'd0, v); check("R6 pending", v, '0);
      reg_read(2'd1, v); check("R6 mask", v, '0);
      reg_read(2'd2, v); check("R6 polarity", v, '0);
      check("R6 irq", {7'd0, irq_req}, '0);
      rst_n = 1'b1;
      idle(2);

      // R7: register access and unused code
      reg_write(2'd1, 8'hA5); reg_read(2'd1, v); check("R7 mask rw", v, 8'hA5);
      reg_write(2'd2, 8'h3C); reg_read(2'd2, v); check("R7 pol rw", v, 8'h3C);
      reg_write(2'd3, 8'hFF);
      reg_read(2'd3, v); check("R7 code3 reads 0", v, '0);
      reg_read(2'd1, v); check("R7 code3 write no effect mask", v, 8'hA5);
      reg_read(2'd2, v); check("R7 code3 write no effect pol", v, 8'h3C);
      reg_read(2'd0, v); check("R7 code3 write no effect pend", v, '0);
      reg_write(2'd1, 8'h00);

      // R1/R2: every channel, both polarities, both directions
      for (int ch = 0; ch < NCH; ch++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int rising = 0; rising < 2; rising++) begin
               logic [NCH-1:0] expv;
               reg_write(2'd2, pol ? (8'd1 << ch) : 8'd0);
               irq_pin[ch] = rising ? 1'b0 : 1'b1;
               idle(5);
               reg_write(2'd0, 8'h00);
               irq_pin[ch] = rising ? 1'b1 : 1'b0;
               idle(5);
               expv = ((pol == 1 && rising == 0) || (pol == 0 && rising == 1)) ? (8'd1 << ch) : 8'd0;
               reg_read(2'd0, v);
               check(pol ? "R2 falling select" : "R1 rising select", v, expv);
               irq_pin[ch] = 1'b0;
               idle(5);
               reg_write(2'd0, 8'h00);
            end
         end
      end

      // R10: latency through two sync flops and the compare
      reg_write(2'd2, 8'h00);
      irq_pin[4] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      reg_read(2'd0, v); check("R10 not yet after two edges", v, '0);
      @(negedge clk);
      reg_read(2'd0, v); check("R10 set after third edge", v, 8'h10);

      // R3: sticky while pin wiggles
      irq_pin[4] = 1'b0; idle(4); irq_pin[4] = 1'b1; idle(4); irq_pin[4] = 1'b0; idle(4);
      reg_read(2'd0, v); check("R3 sticky", v, 8'h10);
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, v); check("R3 cleared by write 0", v, '0);

      // R9: clearing write lands in the same cycle as a detected edge on channel 3
      irq_pin[3] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, v); check("R9 edge beats clear", v, 8'h08);
      irq_pin[3] = 1'b0; idle(4);
      reg_write(2'd0, 8'h00);

      // R11: polarity flips with steady high and low pins
      irq_pin = 8'hF0; idle(5);
      reg_write(2'd0, 8'h00);
      reg_write(2'd2, 8'hFF); idle(4);
      reg_write(2'd2, 8'h00); idle(4);
      reg_write(2'd2, 8'h5A); idle(4);
      reg_read(2'd0, v); check("R11 polarity change no flag", v, '0);
      irq_pin = 8'h00; idle(5);
      reg_write(2'd2, 8'h00);
      reg_write(2'd0, 8'h00);

      // R8 and R4: software-set flags against a sweep of masks
      for (int f = 0; f < 16; f++) begin
         for (int e = 0; e < 16; e++) begin
            logic [NCH-1:0] fv, ev;
            fv = {f[3:0], f[3:0]};
            ev = {e[3:0], ~e[3:0]};
            reg_write(2'd0, fv);
            reg_write(2'd1, ev);
            reg_read(2'd0, v);
            check("R8 software set", v, fv);
            check("R4 masked OR", {7'd0, irq_req}, {7'd0, |(fv & ev)});
         end
      end

      // R5: request held until the last unmasked flag is cleared
      reg_write(2'd1, 8'h0F);
      reg_write(2'd0, 8'h81);
      idle(6);
      check("R5 held high", {7'd0, irq_req}, 8'd1);
      reg_write(2'd0, 8'h80);
      check("R5 masked flag alone no irq", {7'd0, irq_req}, 8'd0);
      reg_write(2'd0, 8'h02);
      check("R5 high again", {7'd0, irq_req}, 8'd1);
      reg_write(2'd0, 8'h00);
      check("R5 low after clear", {7'd0, irq_req}, 8'd0);

      report();
   end

endmodule